// File: doc/BRIEF.md
# Prioritized UART Interrupt Status Unit

This block sits beside a UART's transmit and receive paths and decides which of five interrupt causes the host should see first. Each cause arrives as a request condition. Before any priority decision, each request is masked by its own enable bit. The block returns one status byte that names the most urgent enabled cause, and it drives an interrupt line that is high while any enabled cause is pending.

Four of the causes are level-sensitive and stay pending while their input condition is high: line-status error, receive data available, receive timeout and modem-status change. The transmit-holding-empty cause is different. It is latched on the rising edge of its condition. It is cleared when a status read reports it, or when the host writes the transmit holding register. So one read retires only the transmit-empty cause that it reports, and the next read shows the next cause down.

The status byte is captured at the read strobe and then held until the next read. The two top bits reflect the FIFO-enable flag, and bit 5 reflects the large-FIFO mode.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, `stat_o` reads 0x01 and `irq_o` is low when no request is driven.
- R2: Priority is fixed, highest first: line status (`ls_req`), then receive data (`rd_req`) and receive timeout (`to_req`) together on level 2, then transmit empty, then modem status (`ms_req`).
- R3: `stat_o[3:0]` encodes the reported cause as follows: line status 0110, receive data 0100, receive timeout 1100, transmit empty 0010, modem status 0000.
- R4: `stat_o[0]` is active-low. It reads 0 when some enabled cause was pending at the read, and 1 with `stat_o[3:1]` = 000 when none was.
- R5: When both level-2 causes are active, receive data (0100) is reported ahead of receive timeout.
- R6: `stat_o[7:6]` read 11 when `fifo_en` was high at the read and 00 otherwise. `stat_o[5]` reads `fifo_en & big_fifo`. `stat_o[4]` always reads 0.
- R7: A read that reports transmit empty clears that cause, so the next read reports the next lower pending cause.
- R8: A pulse on `thr_wr` clears the transmit-empty cause. While `thr_empty` stays high, the cause does not return. It is set again only on the next 0-to-1 edge of `thr_empty`.
- R9: The level-sensitive causes are not cleared by reads. They stay reported for as long as their input stays high.
- R10: `src_en` masks each cause before arbitration: bit 0 line status, bit 1 receive data, bit 2 timeout, bit 3 transmit empty, bit 4 modem status. A masked cause is never reported.
- R11: `irq_o` is high exactly when at least one enabled cause is pending.
- R12: `stat_o` takes its value at the clock edge where `stat_rd` is high and holds it until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ls_req | input | 1 | Line-status error condition |
| rd_req | input | 1 | Receive data available condition |
| to_req | input | 1 | Receive timeout condition |
| thr_empty | input | 1 | Transmit holding register empty condition |
| ms_req | input | 1 | Modem-status change condition |
| src_en | input | 5 | Per-cause enable mask |
| thr_wr | input | 1 | Write strobe to the transmit holding register |
| fifo_en | input | 1 | FIFOs enabled flag |
| big_fifo | input | 1 | Large-FIFO mode flag |
| stat_rd | input | 1 | Status register read strobe |
| stat_o | output | 8 | Captured status byte |
| irq_o | output | 1 | Interrupt request line |

## Verification
The assertions assume that every input is synchronous to `clk` and stays stable for a whole cycle. They also assume that `stat_rd` is a single-cycle strobe, so that every capture has a defined previous value to compare against. The bench changes inputs only on the falling edge. It keeps `stat_rd` high for exactly one cycle per read. Whenever the transmit-empty cause has to be pending, the bench first clears it with `thr_wr` while `thr_empty` is low, then raises `thr_empty` to create a clean edge.

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ls_req,
  input  logic            rd_req,
  input  logic            to_req,
  input  logic            thr_empty,
  input  logic            ms_req,
  input  logic [NSRC-1:0] src_en,
  input  logic            thr_wr,
  input  logic            fifo_en,
  input  logic            big_fifo,
  input  logic            stat_rd,
  output logic [7:0]      stat_o,
  output logic            irq_o
);
  localparam logic [3:0] C_LS   = 4'b0110;
  localparam logic [3:0] C_RD   = 4'b0100;
  localparam logic [3:0] C_TO   = 4'b1100;
  localparam logic [3:0] C_THR  = 4'b0010;
  localparam logic [3:0] C_MS   = 4'b0000;
  localparam logic [3:0] C_NONE = 4'b0001;

  logic            thr_prev, thr_pend;
  logic [3:0]      code;
  logic [7:0]      stat_q;
  logic [NSRC-1:0] act;

  wire thr_rise  = thr_empty & ~thr_prev;
  wire thr_taken = stat_rd & (code == C_THR);

  assign act = {ms_req, thr_pend, to_req, rd_req, ls_req} & src_en;

  always_comb begin
    if      (act[0]) code = C_LS;
    else if (act[1]) code = C_RD;
    else if (act[2]) code = C_TO;
    else if (act[3]) code = C_THR;
    else if (act[4]) code = C_MS;
    else             code = C_NONE;
  end

  wire [7:0] stat_now = {fifo_en, fifo_en, fifo_en & big_fifo, 1'b0, code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_prev <= 1'b0;
      thr_pend <= 1'b0;
      stat_q   <= 8'h01;
    end else begin
      thr_prev <= thr_empty;
      thr_pend <= thr_rise | (thr_pend & ~thr_taken & ~thr_wr);
      if (stat_rd) stat_q <= stat_now;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |act;
endmodule

module uart_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ls_req,
  input logic       thr_empty,
  input logic [4:0] src_en,
  input logic       thr_wr,
  input logic       fifo_en,
  input logic       stat_rd,
  input logic [7:0] stat_o,
  input logic       irq_o,
  input logic       thr_pend
);
  AST_BIT4_ZERO: assert property (@(posedge clk) disable iff (!rst_n) stat_o[4] == 1'b0); // R6
  AST_FLAGS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> stat_o[7:6] == {2{$past(fifo_en)}}); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> $stable(stat_o)); // R12
  AST_PEND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && irq_o) |=> stat_o[0] == 1'b0); // R4
  AST_NONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_o) |=> stat_o[3:0] == 4'b0001); // R11
  AST_LS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && ls_req && src_en[0]) |=> stat_o[3:0] == 4'b0110); // R2
  AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thr_empty) |=> !thr_pend); // R8
endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ls_req(ls_req), .thr_empty(thr_empty),
  .src_en(src_en), .thr_wr(thr_wr), .fifo_en(fifo_en), .stat_rd(stat_rd),
  .stat_o(stat_o), .irq_o(irq_o), .thr_pend(thr_pend)
);

// File: tb/test_uart_irq_arbiter.sv
module test_uart_irq_arbiter;
  logic clk = 0, rst_n = 0;
  logic ls_req = 0, rd_req = 0, to_req = 0, thr_empty = 0, ms_req = 0;
  logic [4:0] src_en = 0;
  logic thr_wr = 0, fifo_en = 0, big_fifo = 0, stat_rd = 0;
  logic [7:0] stat_o;
  logic irq_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_arbiter i_uart_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .ls_req(ls_req), .rd_req(rd_req), .to_req(to_req),
    .thr_empty(thr_empty), .ms_req(ms_req), .src_en(src_en), .thr_wr(thr_wr),
    .fifo_en(fifo_en), .big_fifo(big_fifo), .stat_rd(stat_rd),
    .stat_o(stat_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_stat(input logic [4:0] m, input logic [4:0] e,
                                             input logic fe, input logic bf);
    logic [4:0] v;
    logic [3:0] c;
    v = m & e;
    if      (v[0]) c = 4'd6;
    else if (v[1]) c = 4'd4;
    else if (v[2]) c = 4'd12;
    else if (v[3]) c = 4'd2;
    else if (v[4]) c = 4'd0;
    else           c = 4'd1;
    return {fe, fe, fe & bf, 1'b0, c};
  endfunction

  task automatic do_read();
    @(negedge clk) stat_rd = 1;
    @(negedge clk) stat_rd = 0;
  endtask

  task automatic setup(input logic [4:0] m, input logic [4:0] e);
    @(negedge clk);
    {ms_req, to_req, rd_req, ls_req} = {m[4], m[2], m[1], m[0]};
    src_en = e; thr_empty = 0; thr_wr = 1;
    @(negedge clk);
    thr_wr = 0; thr_empty = m[3];
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset stat", stat_o, 8'h01);
    chk("R1 reset irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1;

    for (int f = 0; f < 4; f++) begin
      fifo_en = f[1]; big_fifo = f[0];
      for (int m = 0; m < 32; m++) begin
        for (int e = 0; e < 32; e++) begin
          setup(m[4:0], e[4:0]);
          chk("R10 R11 irq", {7'd0, irq_o}, {7'd0, |(m[4:0] & e[4:0])});
          do_read();
          chk("R2 R3 R4 R5 R6 R10 stat", stat_o, expect_stat(m[4:0], e[4:0], fifo_en, big_fifo));
        end
      end
    end
    fifo_en = 0; big_fifo = 0;

    setup(5'b11000, 5'b11111);
    do_read(); chk("R7 first read thr", stat_o, 8'h02);
    do_read(); chk("R7 next read lower", stat_o, 8'h00);
    ms_req = 0;
    do_read(); chk("R7 thr retired", stat_o, 8'h01);
    chk("R7 irq low", {7'd0, irq_o}, 8'h00);

    setup(5'b01000, 5'b11111);
    @(negedge clk) thr_wr = 1;
    @(negedge clk) thr_wr = 0;
    repeat (3) @(negedge clk);
    chk("R8 wr clears, held level no reset", {7'd0, irq_o}, 8'h00);
    do_read(); chk("R8 stat after wr", stat_o, 8'h01);
    thr_empty = 0;
    @(negedge clk) thr_empty = 1;
    @(negedge clk);
    do_read(); chk("R8 re-set on edge", stat_o, 8'h02);

    setup(5'b00001, 5'b11111);
    do_read(); chk("R9 ls first read", stat_o, 8'h06);
    do_read(); chk("R9 ls persists", stat_o, 8'h06);
    ls_req = 0; rd_req = 1;
    do_read(); chk("R9 rd after ls drop", stat_o, 8'h04);

    ls_req = 1; fifo_en = 1;
    repeat (3) @(negedge clk);
    chk("R12 hold without read", stat_o, 8'h04);
    do_read(); chk("R12 capture on read", stat_o, 8'hC6);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule